// File: doc/BRIEF.md
# Gate Drive Bridge Sequencer

This block sequences the four switch enables of an H-bridge that feeds the gate of a thyristor-type power device stacked in series with others. The bridge has two legs, A and B. Each leg has a high switch and a low switch. The diagonal pair A-high/B-low injects turn-on current. The opposite diagonal pair A-low/B-high extracts gate charge at turn-off. A-low on its own holds the gate at negative bias while the device is off.

A single trigger arrives from an isolated receiver and passes through a two-flop synchronizer and a glitch filter. The rising and falling edges of the filtered trigger are then delayed by separate programmable cycle counts. This lets every drive in a stack align its own switching instant. From the delayed trigger the block walks the bridge through idle, turn-on, turn-off pulse and back to idle. A dead-time with all four switches open separates every hand-over between the diagonals. The turn-off pulse on B-high has a programmed length and ends on its own.

A fault interlock input overrides everything. The bridge goes safely to the bias-only state, the fault is latched, and triggers are ignored until a clear arrives while the trigger is low. A 2-bit status output reports the phase.

Top module: `gate_bridge_seq`

## Requirements
- R1: While reset is held and after it is released with no trigger, only `drv_a_lo` is 1, the other three enables are 0, and `phase_code` is 0 (idle).
- R2: A level change of `trig_in` is accepted only if the synchronized level holds for at least `filt_len`+1 consecutive cycles. A pulse that lasts `filt_len` cycles or fewer leaves the bridge idle with `drv_a_lo` at 1.
- R3: After `trig_in` rises, `drv_a_lo` drops exactly 5+`filt_len`+`rise_dly` cycles later. `drv_a_hi` and `drv_b_lo` rise a further `dead_len`+1 cycles after that.
- R4: After `trig_in` falls, `drv_a_hi` and `drv_b_lo` drop exactly 5+`filt_len`+`fall_dly` cycles later. `drv_a_lo` and `drv_b_hi` rise a further `dead_len`+1 cycles after that. The falling delay is independent of `rise_dly`.
- R5: `drv_b_hi` stays 1 for exactly `off_len`+1 cycles (0 gives one cycle) and then drops by itself. `drv_a_lo` stays 1 and the bridge returns to idle.
- R6: `drv_a_hi` and `drv_a_lo` are never 1 together, and neither are `drv_b_hi` and `drv_b_lo`. Every hand-over between the diagonals passes through `dead_len`+1 cycles with all four enables 0.
- R7: If the delayed trigger rises again during a turn-off pulse, the pulse still runs its full length. The bridge spends one cycle idle and only then starts a new turn-on.
- R8: When `fault_in` is 1, the next cycle shows `drv_a_hi`, `drv_b_hi` and `drv_b_lo` all 0. If the bridge was on, all four enables stay 0 for `dead_len`+1 cycles, after which only `drv_a_lo` is 1 and `phase_code` is 3. Triggers then cause no turn-on.
- R9: A fault stays latched (`phase_code` 3) after `fault_in` returns to 0. A one-cycle `fault_clr` is ignored while the filtered trigger is high. When the trigger is low, it returns the bridge to idle (`phase_code` 0).
- R10: `phase_code` reads 1 from the start of the turn-on dead-time until the on state ends, and 2 from the start of the turn-off dead-time until the turn-off pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger from the isolated receiver |
| fault_in | input | 1 | Fault interlock, synchronous, active high |
| fault_clr | input | 1 | Fault clear request, honoured only while the trigger is low |
| filt_len | input | 4 | Glitch filter length in cycles |
| rise_dly | input | 16 | Extra delay applied to the trigger's leading edge, cycles |
| fall_dly | input | 16 | Extra delay applied to the trigger's trailing edge, cycles |
| dead_len | input | 8 | Dead-time minus one, cycles |
| off_len | input | 16 | Turn-off pulse length minus one, cycles |
| drv_a_hi | output | 1 | Enable, leg A high switch (turn-on diagonal) |
| drv_a_lo | output | 1 | Enable, leg A low switch (negative bias return) |
| drv_b_hi | output | 1 | Enable, leg B high switch (turn-off pulse) |
| drv_b_lo | output | 1 | Enable, leg B low switch (turn-on diagonal) |
| phase_code | output | 2 | 0 idle, 1 on, 2 turn-off, 3 fault |

## Verification
The hardest situation to reach is a new leading edge landing inside a running turn-off pulse. The trigger must be timed so that, after synchronization, filtering and the rising delay, it arrives while B-high is still enabled. The bench computes that window from the programmed lengths, using a long turn-off pulse and a short low time. It then checks that the pulse runs to full length, that one idle cycle follows, and that the new turn-on comes after that. Randomized pulses with drawn filter, delay, dead-time and pulse lengths cover the latency arithmetic. Directed sequences cover the glitch boundary and the fault latch with its guarded clear.

// File: rtl/gbs_pkg.sv
// Shared types for the gate drive bridge sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package gbs_pkg;

    // Bridge sequencing states (one hand-over gap per diagonal change).
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GAP_ON  = 3'd1,
        ST_ON      = 3'd2,
        ST_GAP_OFF = 3'd3,
        ST_TOFF    = 3'd4,
        ST_GAP_FLT = 3'd5,
        ST_FAULT   = 3'd6
    } bridge_st_t;

    // Status codes reported on phase_code.
    localparam logic [1:0] PH_IDLE  = 2'd0;
    localparam logic [1:0] PH_ON    = 2'd1;
    localparam logic [1:0] PH_TOFF  = 2'd2;
    localparam logic [1:0] PH_FAULT = 2'd3;

    // Four switch enables of the bridge.
    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic b_hi;
        logic b_lo;
    } sw_en_t;

    // Switch pattern for each state.
    function automatic sw_en_t sw_of(input bridge_st_t st);
        sw_en_t s;
        s = '0;
        unique case (st)
            ST_IDLE, ST_FAULT: s.a_lo = 1'b1;
            ST_ON:             begin s.a_hi = 1'b1; s.b_lo = 1'b1; end
            ST_TOFF:           begin s.a_lo = 1'b1; s.b_hi = 1'b1; end
            default:           s = '0;
        endcase
        return s;
    endfunction

    // Status code for each state.
    function automatic logic [1:0] ph_of(input bridge_st_t st);
        logic [1:0] p;
        unique case (st)
            ST_IDLE:                p = PH_IDLE;
            ST_GAP_ON, ST_ON:       p = PH_ON;
            ST_GAP_OFF, ST_TOFF:    p = PH_TOFF;
            default:                p = PH_FAULT;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/gbs_trig_cond.sv
// Trigger conditioner: multi-flop synchronizer followed by a glitch filter.
// The filtered level follows the synchronized level only after the latter
// has differed from it for filt_len+1 consecutive cycles.
// Assumes: trig_raw is asynchronous; SYNC_STAGES >= 2.
module gbs_trig_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_raw,
    input  logic [FILT_W-1:0] filt_len,
    output logic              trig_clean
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic [FILT_W-1:0]      run_cnt;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // Shift the raw trigger through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_raw};
    end

    // Count how long the synchronized level disagrees; accept after filt_len+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_clean <= 1'b0;
            run_cnt    <= '0;
        end else if (sync_lvl == trig_clean) begin
            run_cnt <= '0;
        end else if (run_cnt >= filt_len) begin
            trig_clean <= sync_lvl;
            run_cnt    <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: the filtered level only ever moves to the synchronized level.
    p_filt_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clean != $past(trig_clean)) |-> (trig_clean == $past(sync_lvl)));

endmodule

// File: rtl/gbs_edge_delay.sv
// Asymmetric edge delay: the output follows the input level after rise_dly
// cycles for a rising change and fall_dly cycles for a falling change,
// measured from one cycle after the input changes. A change that reverts
// before its delay expires is dropped.
// Assumes: delays are stable while a change is pending.
module gbs_edge_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             lvl_out
);

    logic [DLY_W-1:0] wait_cnt;
    logic [DLY_W-1:0] target;

    // Pick the delay matching the direction of the pending change.
    always_comb target = lvl_in ? rise_dly : fall_dly;

    // Count cycles of disagreement and move the output when the target is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_out  <= 1'b0;
            wait_cnt <= '0;
        end else if (lvl_in == lvl_out) begin
            wait_cnt <= '0;
        end else if (wait_cnt == target) begin
            lvl_out  <= lvl_in;
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // R3/R4: the delayed level only moves to the undelayed level.
    p_dly_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_out != $past(lvl_out)) |-> (lvl_out == $past(lvl_in)));

endmodule

// File: rtl/gbs_bridge_fsm.sv
// Bridge phase sequencer: walks idle -> gap -> on -> gap -> turn-off pulse
// -> idle on the delayed trigger, with a fault path through a gap into a
// latched bias-only state. Enables are decoded from the state register.
// Assumes: fault_in and fault_clr are synchronous to clk.
module gbs_bridge_fsm
    import gbs_pkg::*;
#(
    parameter int DLY_W  = 16,
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_dly,
    input  logic              trig_clean,
    input  logic              fault_in,
    input  logic              fault_clr,
    input  logic [DEAD_W-1:0] dead_len,
    input  logic [DLY_W-1:0]  off_len,
    output sw_en_t            sw,
    output logic [1:0]        phase
);

    bridge_st_t        st_q, st_nx;
    logic [DEAD_W-1:0] gap_cnt;
    logic [DLY_W-1:0]  toff_cnt;
    logic              fault_lat;
    logic              fault_now;
    logic              gap_done;
    logic              toff_done;
    logic              in_gap;

    assign fault_now = fault_in | fault_lat;
    assign gap_done  = (gap_cnt == dead_len);
    assign toff_done = (toff_cnt == off_len);
    assign in_gap    = (st_q == ST_GAP_ON) || (st_q == ST_GAP_OFF) ||
                       (st_q == ST_GAP_FLT);

    // Next-state selection; fault takes precedence over trigger.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:    if (fault_now) st_nx = ST_FAULT;
                        else if (trig_dly) st_nx = ST_GAP_ON;
            ST_GAP_ON:  if (fault_now) st_nx = ST_FAULT;
                        else if (gap_done) st_nx = ST_ON;
            ST_ON:      if (fault_now) st_nx = ST_GAP_FLT;
                        else if (!trig_dly) st_nx = ST_GAP_OFF;
            ST_GAP_OFF: if (fault_now) st_nx = ST_GAP_FLT;
                        else if (gap_done) st_nx = ST_TOFF;
            ST_TOFF:    if (fault_now) st_nx = ST_FAULT;
                        else if (toff_done) st_nx = ST_IDLE;
            ST_GAP_FLT: if (gap_done) st_nx = ST_FAULT;
            ST_FAULT:   if (!fault_now && !trig_dly) st_nx = ST_IDLE;
            default:    st_nx = ST_FAULT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Dead-time counter, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || st_nx != st_q) gap_cnt <= '0;
        else if (in_gap)             gap_cnt <= gap_cnt + 1'b1;
    end

    // Turn-off pulse length counter, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || st_nx != st_q) toff_cnt <= '0;
        else if (st_q == ST_TOFF)    toff_cnt <= toff_cnt + 1'b1;
    end

    // Fault latch: set by the interlock, cleared only with the trigger low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     fault_lat <= 1'b0;
        else if (fault_in)                              fault_lat <= 1'b1;
        else if (fault_clr && !trig_clean)              fault_lat <= 1'b0;
    end

    // Decode enables and status from the state.
    always_comb begin
        sw    = sw_of(st_q);
        phase = ph_of(st_q);
    end

    // R6: no leg ever has both switches enabled.
    p_leg_a_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw.a_hi && sw.a_lo));
    p_leg_b_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw.b_hi && sw.b_lo));
    // R6: turn-on diagonal only closes after a cycle with leg A low open.
    p_gap_before_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw.a_hi) |-> !$past(sw.a_lo));
    // R6: turn-off switch only closes after the turn-on diagonal is open.
    p_gap_before_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw.b_hi) |-> (!$past(sw.b_lo) && !$past(sw.a_hi)));
    // R5: when the turn-off pulse ends, bias stays applied.
    p_toff_end_bias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw.b_hi) |-> sw.a_lo);
    // R8: a fault opens every switch but the bias return on the next cycle.
    p_fault_safe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> (!sw.a_hi && !sw.b_hi && !sw.b_lo));
    // R9: the latch only releases on a clear taken with the trigger low.
    p_clear_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_lat) |-> ($past(fault_clr) && !$past(trig_clean)));

endmodule

// File: rtl/gate_bridge_seq.sv
// Gate drive bridge sequencer top: conditions the trigger, applies the
// asymmetric edge delays and drives the four bridge enables.
// Assumes: fault_in/fault_clr synchronous; trig_in asynchronous.
module gate_bridge_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 4,
    parameter int DLY_W       = 16,
    parameter int DEAD_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              fault_in,
    input  logic              fault_clr,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [DLY_W-1:0]  rise_dly,
    input  logic [DLY_W-1:0]  fall_dly,
    input  logic [DEAD_W-1:0] dead_len,
    input  logic [DLY_W-1:0]  off_len,
    output logic              drv_a_hi,
    output logic              drv_a_lo,
    output logic              drv_b_hi,
    output logic              drv_b_lo,
    output logic [1:0]        phase_code
);

    import gbs_pkg::*;

    logic   trig_clean;
    logic   trig_dly;
    sw_en_t sw;

    gbs_trig_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_W      (FILT_W)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_raw   (trig_in),
        .filt_len   (filt_len),
        .trig_clean (trig_clean)
    );

    gbs_edge_delay #(
        .DLY_W (DLY_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (trig_clean),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .lvl_out  (trig_dly)
    );

    gbs_bridge_fsm #(
        .DLY_W  (DLY_W),
        .DEAD_W (DEAD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_dly   (trig_dly),
        .trig_clean (trig_clean),
        .fault_in   (fault_in),
        .fault_clr  (fault_clr),
        .dead_len   (dead_len),
        .off_len    (off_len),
        .sw         (sw),
        .phase      (phase_code)
    );

    // Break the enable struct out onto the ports.
    always_comb begin
        drv_a_hi = sw.a_hi;
        drv_a_lo = sw.a_lo;
        drv_b_hi = sw.b_hi;
        drv_b_lo = sw.b_lo;
    end

endmodule

// File: tb/gate_bridge_seq_bench.sv
`timescale 1ns/1ps
module gate_bridge_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        fault_in = 1'b0;
    logic        fault_clr = 1'b0;
    logic [3:0]  filt_len = '0;
    logic [15:0] rise_dly = '0;
    logic [15:0] fall_dly = '0;
    logic [7:0]  dead_len = '0;
    logic [15:0] off_len = '0;
    logic        drv_a_hi, drv_a_lo, drv_b_hi, drv_b_lo;
    logic [1:0]  phase_code;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    bit mon_on = 0;
    int overlap_cnt = 0;
    int t_alo_fall, t_alo_rise, t_ahi_rise, t_ahi_fall, t_bhi_rise, t_bhi_fall;
    int ph_at_bhi;
    logic p_alo, p_ahi, p_bhi;

    always #2.5 clk = ~clk;

    gate_bridge_seq u_gate_bridge_seq (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .fault_in(fault_in),
        .fault_clr(fault_clr), .filt_len(filt_len), .rise_dly(rise_dly),
        .fall_dly(fall_dly), .dead_len(dead_len), .off_len(off_len),
        .drv_a_hi(drv_a_hi), .drv_a_lo(drv_a_lo), .drv_b_hi(drv_b_hi),
        .drv_b_lo(drv_b_lo), .phase_code(phase_code)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Expected latencies derived from the requirements.
    function automatic int lat_edge(input int f, input int d);
        return 5 + f + d;
    endfunction
    function automatic int lat_swap(input int f, input int d, input int g);
        return 5 + f + d + g + 1;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_times();
        t_alo_fall = -1; t_alo_rise = -1; t_ahi_rise = -1;
        t_ahi_fall = -1; t_bhi_rise = -1; t_bhi_fall = -1; ph_at_bhi = -1;
    endtask

    // Event recorder: timestamps enable transitions, counts leg overlaps.
    always @(negedge clk) begin
        if (mon_on) begin
            if ((drv_a_hi && drv_a_lo) || (drv_b_hi && drv_b_lo)) overlap_cnt++;
            if (p_alo && !drv_a_lo) t_alo_fall = cyc;
            if (!p_alo && drv_a_lo) t_alo_rise = cyc;
            if (!p_ahi && drv_a_hi) t_ahi_rise = cyc;
            if (p_ahi && !drv_a_hi) t_ahi_fall = cyc;
            if (!p_bhi && drv_b_hi) begin t_bhi_rise = cyc; ph_at_bhi = phase_code; end
            if (p_bhi && !drv_b_hi) t_bhi_fall = cyc;
        end
        p_alo = drv_a_lo; p_ahi = drv_a_hi; p_bhi = drv_b_hi;
    end

    task automatic set_cfg(input int f, input int dr, input int df, input int g, input int t);
        filt_len = 4'(f); rise_dly = 16'(dr); fall_dly = 16'(df);
        dead_len = 8'(g); off_len = 16'(t);
    endtask

    // One full trigger pulse with latency checks for R3, R4, R5, R10.
    task automatic run_pulse(input int f, input int dr, input int df, input int g,
                             input int t, input int w);
        int t0, tf;
        set_cfg(f, dr, df, g, t);
        repeat (4) @(negedge clk);
        clear_times();
        t0 = cyc; trig_in = 1'b1;
        repeat (w) @(negedge clk);
        check("R10", "phase while on", phase_code, 1);
        check("R3", "a_hi while on", drv_a_hi, 1);
        tf = cyc; trig_in = 1'b0;
        repeat (f + df + g + t + 20) @(negedge clk);
        check("R3", "a_lo fall time", t_alo_fall - t0, lat_edge(f, dr));
        check("R3", "a_hi rise time", t_ahi_rise - t0, lat_swap(f, dr, g));
        check("R4", "a_hi fall time", t_ahi_fall - tf, lat_edge(f, df));
        check("R4", "b_hi rise time", t_bhi_rise - tf, lat_swap(f, df, g));
        check("R5", "b_hi pulse width", t_bhi_fall - t_bhi_rise, t + 1);
        check("R10", "phase in turn-off", ph_at_bhi, 2);
        check("R5", "idle after pulse a_lo", drv_a_lo, 1);
        check("R5", "idle after pulse phase", phase_code, 0);
    endtask

    initial begin
        int tf, t0, tfa;
        clear_times();
        repeat (5) @(negedge clk);
        check("R1", "a_lo in reset", drv_a_lo, 1);
        check("R1", "a_hi|b_hi|b_lo in reset", drv_a_hi | drv_b_hi | drv_b_lo, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", "a_lo after reset", drv_a_lo, 1);
        check("R1", "phase after reset", phase_code, 0);

        // Directed: zero settings, then asymmetric delays.
        run_pulse(0, 0, 0, 0, 0, 10);
        run_pulse(1, 12, 3, 2, 7, 24);
        run_pulse(0, 2, 17, 0, 4, 12);

        // R2 glitch filter boundary with filt_len = 2.
        set_cfg(2, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        clear_times();
        trig_in = 1'b1; repeat (2) @(negedge clk); trig_in = 1'b0;
        repeat (20) @(negedge clk);
        check("R2", "short pulse leaves a_lo", t_alo_fall, -1);
        check("R2", "short pulse phase", phase_code, 0);
        clear_times();
        t0 = cyc;
        trig_in = 1'b1; repeat (3) @(negedge clk); trig_in = 1'b0;
        repeat (30) @(negedge clk);
        check("R2", "3-cycle pulse accepted", t_alo_fall - t0, lat_edge(2, 0));

        // Random pulses with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 10; i++) begin
            int f, dr, df, g, t;
            f = $urandom % 4; dr = $urandom % 21; df = $urandom % 21;
            g = $urandom % 4; t = $urandom % 25;
            run_pulse(f, dr, df, g, t, f + dr + g + 8 + ($urandom % 10));
        end

        // R7 re-trigger inside the turn-off pulse.
        set_cfg(0, 0, 0, 1, 30);
        repeat (4) @(negedge clk);
        trig_in = 1'b1; repeat (20) @(negedge clk);
        clear_times();
        tf = cyc; trig_in = 1'b0;
        repeat (10) @(negedge clk);
        trig_in = 1'b1;
        repeat (50) @(negedge clk);
        check("R7", "b_hi full width", t_bhi_fall - t_bhi_rise, 31);
        check("R7", "b_hi fall time", t_bhi_fall - tf, lat_swap(0, 0, 1) + 31);
        check("R7", "new a_lo fall one cycle after", t_alo_fall - t_bhi_fall, 1);
        check("R7", "new a_hi rise", t_ahi_rise - t_bhi_fall, 1 + 2);
        trig_in = 1'b0;
        repeat (60) @(negedge clk);

        // R8 fault while on, R9 latch and guarded clear.
        set_cfg(0, 0, 0, 2, 5);
        trig_in = 1'b1;
        while (!drv_a_hi) @(negedge clk);
        tfa = cyc; fault_in = 1'b1;
        @(negedge clk);
        check("R8", "all open after fault", {drv_a_hi, drv_a_lo, drv_b_hi, drv_b_lo}, 0);
        repeat (2) @(negedge clk);
        check("R8", "gap still open", drv_a_lo, 0);
        @(negedge clk);
        check("R8", "bias after gap", {drv_a_hi, drv_a_lo, drv_b_hi, drv_b_lo}, 4'b0100);
        check("R8", "fault phase", phase_code, 3);
        trig_in = 1'b0; repeat (10) @(negedge clk);
        clear_times();
        trig_in = 1'b1; repeat (20) @(negedge clk);
        check("R8", "trigger blocked", t_ahi_rise, -1);
        fault_in = 1'b0; repeat (5) @(negedge clk);
        check("R9", "latched after release", phase_code, 3);
        fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", "clear ignored with trigger high", phase_code, 3);
        trig_in = 1'b0; repeat (10) @(negedge clk);
        check("R9", "still latched before clear", phase_code, 3);
        fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "idle after clear", phase_code, 0);
        check("R9", "bias after clear", drv_a_lo, 1);
        run_pulse(0, 1, 1, 0, 2, 10);

        check("R6", "leg overlap samples", overlap_cnt, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule